// File: doc/BRIEF.md
# Reserved-Address Command Decoder for a Two-Wire Memory Slave

This block sits beside the memory path of a two-wire (I2C) memory slave and handles a reserved-address command sequence. A shared bit-level front end hands it decoded bus events: start or repeated start, stop, each received byte, and the controller's acknowledge bit after each byte the slave sends. The block answers with an acknowledge decision for the bytes it owns, offers outgoing bytes on a valid/ready stream, and keeps a sleep state with a timed wake-up.

The sequence opens with a start and the reserved byte F8h. The slave's own address follows, with its R/W bit ignored. A repeated start and a command code complete it. Code F9h returns a three-byte identity built from parameters: a 12-bit maker field, a 9-bit part field and a 3-bit revision, packed MSB first. Code CDh returns an eight-byte serial number. Its first seven bytes come from an input port and the last byte is a CRC computed over them. Code 86h, followed by a stop, puts the slave to sleep. While asleep it keeps decoding. Its own address wakes it, and then it refuses its own address until a recovery count has run out.

The outgoing stream works as follows. `tx_valid` with `tx_data` offers a byte, and the front end takes it by raising `tx_ready`. The byte stays stable until it is taken. No further byte is offered until the controller's acknowledge for the taken byte arrives. The inbound byte and event pulses cannot be stalled. Every received byte gets its response in the next clock cycle.

Top module: `rsv_cmd_dec`

## Requirements
- R1: A byte F8h received as the first byte after a start is acknowledged: one cycle after `rx_valid`, `ack_valid`=1 and `ack_drive`=1 (1 means pull the data line low).
- R2: After F8h, a byte whose bits 7..1 equal {1010b, `dev_sel`} is acknowledged whatever its bit 0 is. Any other byte there gets no response (`ack_valid` stays 0).
- R3: After a matched target and a repeated start, code F9h is acknowledged. The identity bytes 00h, 43h, 00h are then offered in that order by default: maker 004h, part 060h, revision 0 packed MSB first.
- R4: Code CDh is acknowledged and eight bytes follow: `sn_body[55:48]` first through `sn_body[7:0]`, then a CRC-8. The CRC uses polynomial 07h with initial value 00h and runs MSB first over those seven bytes.
- R5: A controller NACK ends a read: `tx_valid` drops and stays low, and the command state returns to idle, so a code byte without a new sequence is not acknowledged.
- R6: An offered byte holds `tx_valid` and `tx_data` stable until `tx_ready`. The next byte appears only after the controller's ACK. After the last byte, an ACK wraps the read back to the first byte.
- R7: Code 86h is acknowledged, and the stop that follows it sets `asleep`=1 and `ready`=0 in the next cycle.
- R8: A broken sequence (unknown code, a stop before the code, or a start instead of the stop after 86h) gets no acknowledge for the bad byte and leaves `asleep` unchanged.
- R9: While asleep, the own address arriving as the first byte after a start (or as the target after F8h) clears `asleep`. `ready` then stays 0 for exactly WAKE_CYC cycles before rising. A foreign address does not wake the block.
- R10: While `ready`=0, the own address gets an explicit NACK (`ack_valid`=1, `ack_drive`=0), both as a plain address and as a target after F8h. While ready, a plain own address gets no response from this block.
- R11: After reset: `asleep`=0, `ready`=1, `tx_valid`=0, `ack_valid`=0.
- R12: A start during a read aborts it; `tx_valid` is 0 in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_sel | input | 3 | Device select bits of the slave address |
| sn_body | input | 56 | Seven serial-number bytes, most significant byte sent first |
| bus_start | input | 1 | One-cycle pulse: start or repeated start seen |
| bus_stop | input | 1 | One-cycle pulse: stop seen |
| rx_valid | input | 1 | One-cycle pulse: a full byte was received |
| rx_data | input | 8 | Received byte, valid with rx_valid |
| ack_valid | output | 1 | This block has an acknowledge decision for the last byte |
| ack_drive | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| tx_valid | output | 1 | Outgoing byte offered |
| tx_ready | input | 1 | Front end takes the offered byte |
| tx_data | output | 8 | Outgoing byte |
| mst_ack_valid | input | 1 | Controller's acknowledge bit for a sent byte is available |
| mst_ack | input | 1 | 1 = controller acknowledged, 0 = NACK |
| asleep | output | 1 | Sleep state |
| ready | output | 1 | Neither asleep nor counting down the recovery time |

## Verification
The assertions assume that the front end never raises two of `bus_start`, `bus_stop` and `rx_valid` in the same cycle. They also assume that `tx_ready` comes only while a byte is offered, and that `mst_ack_valid` comes only after a taken byte. The stimulus keeps to this by driving every event as a single one-cycle pulse from its own task, with at least one quiet cycle after it. It reads bytes only while `tx_valid` is high, and it returns the controller's acknowledge one cycle after the take.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam logic [7:0] CODE_TARGET = 8'hF8;
  localparam logic [7:0] CODE_IDENT  = 8'hF9;
  localparam logic [7:0] CODE_SERIAL = 8'hCD;
  localparam logic [7:0] CODE_SLEEP  = 8'h86;
  localparam logic [3:0] DEV_TYPE    = 4'hA;
  localparam int unsigned ID_BYTES   = 3;
  localparam int unsigned SN_BYTES   = 8;
  localparam int unsigned IDX_W      = $clog2(SN_BYTES);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TGT,
    ST_ARMED,
    ST_CODE,
    ST_ID,
    ST_SN,
    ST_SLP,
    ST_SKIP
  } seq_st_t;
endpackage

// File: rtl/rsv_sleep_ctl.sv
module rsv_sleep_ctl #(
  parameter int unsigned WAKE_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  output logic asleep,
  output logic ready
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          asleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      cnt_q    <= '0;
    end else if (wake_req && asleep_q) begin
      asleep_q <= 1'b0;
      cnt_q    <= CW'(WAKE_CYC);
    end else if (sleep_req) begin
      asleep_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign asleep = asleep_q;
  assign ready  = !asleep_q && (cnt_q == '0);

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_q) |-> $past(sleep_req)) else $error("sleep without request"); // R7
  AST_WAKE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep_q) |-> $past(wake_req)) else $error("wake without request"); // R9
  AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep_q) |-> !ready) else $error("ready right after wake"); // R9
endmodule

// File: rtl/rsv_byte_src.sv
module rsv_byte_src
  import rsv_pkg::*;
#(
  parameter logic [11:0] MAKER_ID = 12'h004,
  parameter logic [8:0]  PART_ID  = 9'h060,
  parameter logic [2:0]  REV_ID   = 3'h0
) (
  input  logic             sel_sn,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [55:0]      sn_body,
  output logic [7:0]       byte_out
);
  localparam int unsigned IDW = 8 * ID_BYTES;
  localparam logic [IDW-1:0] ID_WORD = {MAKER_ID, PART_ID, REV_ID};
  localparam int unsigned BODY_BYTES = SN_BYTES - 1;

  function automatic logic [7:0] crc8_msb(input logic [8*BODY_BYTES-1:0] d);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 8 * BODY_BYTES - 1; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  logic [7:0] id_b [ID_BYTES];
  logic [7:0] sn_b [SN_BYTES];

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    assign id_b[g] = ID_WORD[IDW-1-8*g -: 8];
  end

  for (genvar g = 0; g < BODY_BYTES; g++) begin : g_sn
    assign sn_b[g] = sn_body[8*BODY_BYTES-1-8*g -: 8];
  end
  assign sn_b[SN_BYTES-1] = crc8_msb(sn_body);

  always_comb begin
    byte_out = 8'h00;
    if (sel_sn) begin
      for (int i = 0; i < SN_BYTES; i++)
        if (byte_idx == IDX_W'(i)) byte_out = sn_b[i];
    end else begin
      for (int i = 0; i < ID_BYTES; i++)
        if (byte_idx == IDX_W'(i)) byte_out = id_b[i];
    end
  end
endmodule

// File: rtl/rsv_seq_fsm.sv
module rsv_seq_fsm
  import rsv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       dev_sel,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             ready,
  input  logic             asleep,
  input  logic             tx_ready,
  input  logic             mst_ack_valid,
  input  logic             mst_ack,
  output logic             ack_valid,
  output logic             ack_drive,
  output logic             tx_valid,
  output logic             sel_sn,
  output logic [IDX_W-1:0] byte_idx,
  output logic             sleep_req,
  output logic             wake_req
);
  seq_st_t          st_q;
  logic             await_q;
  logic [IDX_W-1:0] idx_q;
  logic             ackv_q, ackd_q;
  logic             own_addr;
  logic             in_read;
  logic [IDX_W-1:0] last_idx;

  assign own_addr = (rx_data[7:1] == {DEV_TYPE, dev_sel});
  assign in_read  = (st_q == ST_ID) || (st_q == ST_SN);
  assign last_idx = (st_q == ST_SN) ? IDX_W'(SN_BYTES - 1) : IDX_W'(ID_BYTES - 1);

  assign sleep_req = bus_stop && (st_q == ST_SLP);
  assign wake_req  = rx_valid && !bus_start && !bus_stop && own_addr && asleep &&
                     ((st_q == ST_ADDR) || (st_q == ST_TGT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      await_q <= 1'b0;
      idx_q   <= '0;
      ackv_q  <= 1'b0;
      ackd_q  <= 1'b0;
    end else begin
      ackv_q <= 1'b0;
      ackd_q <= 1'b0;
      if (bus_stop) begin
        st_q    <= ST_IDLE;
        await_q <= 1'b0;
      end else if (bus_start) begin
        st_q    <= (st_q == ST_ARMED) ? ST_CODE : ST_ADDR;
        await_q <= 1'b0;
        idx_q   <= '0;
      end else if (rx_valid) begin
        unique case (st_q)
          ST_ADDR: begin
            st_q <= ST_SKIP;
            if (rx_data == CODE_TARGET) begin
              ackv_q <= 1'b1;
              ackd_q <= 1'b1;
              st_q   <= ST_TGT;
            end else if (own_addr && !ready) begin
              ackv_q <= 1'b1;
              ackd_q <= 1'b0;
            end
          end
          ST_TGT: begin
            st_q <= ST_SKIP;
            if (own_addr) begin
              ackv_q <= 1'b1;
              ackd_q <= ready;
              if (ready) st_q <= ST_ARMED;
            end
          end
          ST_CODE: begin
            idx_q   <= '0;
            await_q <= 1'b0;
            unique case (rx_data)
              CODE_IDENT:  begin ackv_q <= 1'b1; ackd_q <= 1'b1; st_q <= ST_ID;  end
              CODE_SERIAL: begin ackv_q <= 1'b1; ackd_q <= 1'b1; st_q <= ST_SN;  end
              CODE_SLEEP:  begin ackv_q <= 1'b1; ackd_q <= 1'b1; st_q <= ST_SLP; end
              default:     st_q <= ST_SKIP;
            endcase
          end
          ST_ARMED, ST_SLP: st_q <= ST_SKIP;
          default: ;
        endcase
      end else if (in_read) begin
        if (!await_q && tx_ready) begin
          await_q <= 1'b1;
        end else if (await_q && mst_ack_valid) begin
          if (mst_ack) begin
            await_q <= 1'b0;
            idx_q   <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
          end else begin
            st_q    <= ST_IDLE;
            await_q <= 1'b0;
          end
        end
      end
    end
  end

  assign ack_valid = ackv_q;
  assign ack_drive = ackd_q;
  assign tx_valid  = in_read && !await_q;
  assign sel_sn    = (st_q == ST_SN);
  assign byte_idx  = idx_q;

  AST_ACK_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(rx_valid)) else $error("ack without byte"); // R1
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_start && !bus_stop) |=> (tx_valid && $stable(byte_idx) && $stable(sel_sn)))
    else $error("offered byte dropped"); // R6
  AST_NACK_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && await_q && mst_ack_valid && !mst_ack && !bus_start && !bus_stop) |=> !tx_valid)
    else $error("read continued after nack"); // R5
endmodule

// File: rtl/rsv_cmd_dec.sv
module rsv_cmd_dec
  import rsv_pkg::*;
#(
  parameter logic [11:0] MAKER_ID = 12'h004,
  parameter logic [8:0]  PART_ID  = 9'h060,
  parameter logic [2:0]  REV_ID   = 3'h0,
  parameter int unsigned WAKE_CYC = 20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  dev_sel,
  input  logic [55:0] sn_body,
  input  logic        bus_start,
  input  logic        bus_stop,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        ack_valid,
  output logic        ack_drive,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        mst_ack_valid,
  input  logic        mst_ack,
  output logic        asleep,
  output logic        ready
);
  logic             sel_sn;
  logic [IDX_W-1:0] byte_idx;
  logic             sleep_req, wake_req;

  rsv_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .dev_sel       (dev_sel),
    .bus_start     (bus_start),
    .bus_stop      (bus_stop),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .ready         (ready),
    .asleep        (asleep),
    .tx_ready      (tx_ready),
    .mst_ack_valid (mst_ack_valid),
    .mst_ack       (mst_ack),
    .ack_valid     (ack_valid),
    .ack_drive     (ack_drive),
    .tx_valid      (tx_valid),
    .sel_sn        (sel_sn),
    .byte_idx      (byte_idx),
    .sleep_req     (sleep_req),
    .wake_req      (wake_req)
  );

  rsv_byte_src #(
    .MAKER_ID (MAKER_ID),
    .PART_ID  (PART_ID),
    .REV_ID   (REV_ID)
  ) u_src (
    .sel_sn   (sel_sn),
    .byte_idx (byte_idx),
    .sn_body  (sn_body),
    .byte_out (tx_data)
  );

  rsv_sleep_ctl #(
    .WAKE_CYC (WAKE_CYC)
  ) u_slp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .wake_req  (wake_req),
    .asleep    (asleep),
    .ready     (ready)
  );

  AST_OWN_ACK_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_drive && $past(rx_data[7:1] == {DEV_TYPE, dev_sel})) |-> $past(ready))
    else $error("own address acked while not ready"); // R10
  AST_TX_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !asleep) else $error("byte offered while asleep"); // R3
endmodule

// File: tb/rsv_cmd_dec_test.sv
module rsv_cmd_dec_test;
  localparam int unsigned WAKE = 40;
  localparam logic [2:0] MY_SEL = 3'b101;
  localparam logic [7:0] OWN_W = 8'hAA;
  localparam logic [7:0] OWN_R = 8'hAB;
  localparam logic [7:0] OTHER = 8'hA8;
  localparam logic [55:0] SNB = 56'h0123456789ABCD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start = 0, bus_stop = 0, rx_valid = 0, tx_ready = 0;
  logic mst_ack_valid = 0, mst_ack = 0;
  logic [7:0] rx_data = 8'h00;
  logic ack_valid, ack_drive, tx_valid, asleep, ready;
  logic [7:0] tx_data;

  int errors = 0;
  int checks = 0;
  int ticks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rsv_cmd_dec #(.WAKE_CYC(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .dev_sel(MY_SEL), .sn_body(SNB),
    .bus_start(bus_start), .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_data(rx_data),
    .ack_valid(ack_valid), .ack_drive(ack_drive), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .mst_ack_valid(mst_ack_valid), .mst_ack(mst_ack),
    .asleep(asleep), .ready(ready)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    ticks++;
  endtask

  task automatic do_start();
    bus_start = 1; tick(); bus_start = 0;
  endtask

  task automatic do_stop();
    bus_stop = 1; tick(); bus_stop = 0;
  endtask

  // send a byte and check the response one cycle later
  task automatic put(input logic [7:0] b, input logic ev, input logic ed, input string tag);
    rx_valid = 1; rx_data = b; tick(); rx_valid = 0;
    chk({tag, " ack_valid"}, 64'(ack_valid), 64'(ev));
    if (ev) chk({tag, " ack_drive"}, 64'(ack_drive), 64'(ed));
  endtask

  task automatic get(input logic [7:0] exp, input logic mack, input string tag);
    chk({tag, " tx_valid"}, 64'(tx_valid), 64'd1);
    chk({tag, " tx_data"}, 64'(tx_data), 64'(exp));
    tx_ready = 1; tick(); tx_ready = 0;
    chk({tag, " offer withheld"}, 64'(tx_valid), 64'd0);
    mst_ack_valid = 1; mst_ack = mack; tick(); mst_ack_valid = 0; mst_ack = 0;
  endtask

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int k = 6; k >= 0; k--) begin
      c = c ^ d[8*k +: 8];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  task automatic open_seq(input logic [7:0] code, input logic ev, input logic ed, input string tag);
    do_start();
    put(8'hF8, 1, 1, "R1 reserved byte");
    put(OWN_W, 1, 1, "R2 target");
    do_start();
    put(code, ev, ed, tag);
  endtask

  task automatic t_reset();
    chk("R11 asleep", 64'(asleep), 0);
    chk("R11 ready", 64'(ready), 1);
    chk("R11 tx_valid", 64'(tx_valid), 0);
    chk("R11 ack_valid", 64'(ack_valid), 0);
  endtask

  task automatic t_ident();
    do_start();
    put(8'hF8, 1, 1, "R1 reserved byte");
    put(OWN_R, 1, 1, "R2 target bit0 set");
    do_start();
    put(8'hF9, 1, 1, "R3 ident code");
    get(8'h00, 1, "R3 ident byte0");
    get(8'h43, 1, "R3 ident byte1");
    get(8'h00, 1, "R3 ident byte2");
    get(8'h00, 0, "R6 wrap to byte0");
    chk("R5 tx after nack", 64'(tx_valid), 0);
    tick();
    chk("R5 tx stays low", 64'(tx_valid), 0);
    put(8'hF9, 0, 0, "R5 code after nack");
    do_stop();
  endtask

  task automatic t_wrong_target();
    do_start();
    put(8'hF8, 1, 1, "R1 reserved byte");
    put(OTHER, 0, 0, "R2 foreign target");
    do_start();
    put(8'hF9, 0, 0, "R2 code not armed");
    chk("R2 no read", 64'(tx_valid), 0);
    do_stop();
  endtask

  task automatic t_serial();
    logic [7:0] exp;
    open_seq(8'hCD, 1, 1, "R4 serial code");
    tick(); tick(); tick();
    chk("R6 held valid", 64'(tx_valid), 1);
    chk("R6 held data", 64'(tx_data), 64'(SNB[55:48]));
    for (int i = 0; i < 8; i++) begin
      exp = (i < 7) ? SNB[55-8*i -: 8] : ref_crc(SNB);
      get(exp, (i < 7), "R4 serial byte");
    end
    chk("R5 serial ended", 64'(tx_valid), 0);
    do_stop();
  endtask

  task automatic t_abort();
    open_seq(8'hF9, 1, 1, "R3 ident code");
    get(8'h00, 1, "R3 ident byte0");
    do_start();
    chk("R12 abort by start", 64'(tx_valid), 0);
    do_stop();
  endtask

  task automatic t_broken();
    open_seq(8'h55, 0, 0, "R8 unknown code");
    do_stop();
    chk("R8 asleep after bad code", 64'(asleep), 0);
    do_start();
    put(8'hF8, 1, 1, "R1 reserved byte");
    put(OWN_W, 1, 1, "R2 target");
    do_stop();
    chk("R8 early stop", 64'(asleep), 0);
    open_seq(8'h86, 1, 1, "R7 sleep code");
    do_start();
    do_stop();
    chk("R8 start instead of stop", 64'(asleep), 0);
    chk("R8 still ready", 64'(ready), 1);
  endtask

  task automatic t_sleep_wake();
    int t0;
    open_seq(8'h86, 1, 1, "R7 sleep code");
    do_stop();
    chk("R7 asleep", 64'(asleep), 1);
    chk("R7 not ready", 64'(ready), 0);
    do_start();
    put(8'hF8, 1, 1, "R1 reserved while asleep");
    do_stop();
    chk("R8 asleep kept", 64'(asleep), 1);
    do_start();
    put(OTHER, 0, 0, "R9 foreign addr");
    chk("R9 foreign no wake", 64'(asleep), 1);
    do_stop();
    do_start();
    put(OWN_W, 1, 0, "R10 wake addr nacked");
    t0 = ticks;
    chk("R9 woke", 64'(asleep), 0);
    chk("R9 not ready yet", 64'(ready), 0);
    do_stop();
    do_start();
    put(OWN_R, 1, 0, "R10 addr during recovery");
    do_stop();
    do_start();
    put(8'hF8, 1, 1, "R1 reserved during recovery");
    put(OWN_W, 1, 0, "R10 target during recovery");
    do_stop();
    while (ticks < t0 + int'(WAKE) - 1) tick();
    chk("R9 ready low at end-1", 64'(ready), 0);
    tick();
    chk("R9 ready after recovery", 64'(ready), 1);
    do_start();
    put(OWN_W, 0, 0, "R10 ready no response");
    do_stop();
    open_seq(8'hF9, 1, 1, "R3 ident after wake");
    get(8'h00, 0, "R3 ident after wake byte0");
    do_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_ident();
    t_wrong_target();
    t_serial();
    t_abort();
    t_broken();
    t_sleep_wake();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule